// File: doc/BRIEF.md
# Multi-Standard Composite Sync Generator

This block produces the composite sync, composite blanking and vertical drive waveforms of a broadcast television raster, together with a line-start and a field-start strobe that other video blocks use to align with the raster. It advances only on a tick enable. One scan line is 320 ticks long, so every pulse width and delay is a whole number of ticks. A 3-bit standard code selects one of the 625-line or 525-line formats. A separate input switches the raster to progressive operation with 624 or 524 lines, in which every field has the same timing.

Inside, a tick counter, a line counter and a half-line counter with a field flag track the raster position. The half-line counter runs through the vertical interval of each field. In that interval the normal line sync is replaced by a train of narrow equalizing pulses, then a train of broad pulses separated by serration notches, then a second equalizing train. The block decodes the raster position into the outputs and registers them. The outputs move only on ticks.

The line counts are parameters. Their defaults are 625 and 525. A smaller value gives a shorter raster for simulation, while the in-line timing and the vertical interval stay unchanged.

Top module: `tvsync_gen`

## Requirements
- R1: While `rst_n` is low, all pulse outputs and strobes are low, `line_num` is 1 and `field_odd` is 0. The first tick after release shows line 1, tick 0 of the first field, with both strobes high.
- R2: `std_sel` encodings: 000, 001, 100, 101 and 111 give the 625-line group; 010 gives NTSC with 56-tick blanking; 110 gives NTSC with 53-tick blanking; 011 gives PAL-M.
- R3: A line is 320 ticks. `line_start` is high for the tick at position 0 of each line. `line_num` counts 1 up to the frame's line total (the parameter value, or one less in progressive mode) and then returns to 1.
- R4: Outside the vertical interval, `csync` is high at ticks 8 to 31 of each line and is low in the second half of the line.
- R5: Each field opens with a pre-equalizing section and has a post-equalizing section after the broad pulses. Each section lasts 5 half-lines (625 group) or 6 half-lines (525 group). In every half-line of these sections `csync` is high at offsets 8 to 19.
- R6: The broad-pulse section lasts 5 half-lines (625 group), 6 (NTSC) or 7 (PAL-M). In every half-line of it `csync` is high at offsets 8 to 143, which leaves a 24-tick notch before the next pulse edge.
- R7: `cblank` is high at ticks 0 up to the horizontal blanking width minus 1 of every line. The width is 60, or 56 for code 010, or 53 for code 110. Blanking therefore begins 8 ticks ahead of the sync edge.
- R8: Counted from each field start, `cblank` stays high for 50 half-lines (625 group and PAL-M), 42 (code 010) or 38 (code 110), plus one horizontal blanking width.
- R9: `vdrive` rises 16 ticks into the field's first half-line, which is 8 ticks after the first pulse edge. It lasts 20 half-lines (625 group) or 12 half-lines (525 group).
- R10: In interlaced mode a field is as many half-lines as the frame has lines. The second field therefore begins at tick 160 of a line. `field_start` is high for the first tick of each field, and `field_odd` is 1 during the second field.
- R11: In progressive mode both fields begin at tick 0, have identical timing, and together span 624 or 524 lines.
- R12: While `tick_en` is low, every output holds its value and the raster position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Tick enable; 320 ticks per line |
| std_sel | input | 3 | Television standard code |
| noninterlace | input | 1 | 1 selects progressive 624/524-line raster |
| csync | output | 1 | Composite sync, active high |
| cblank | output | 1 | Composite blanking, active high |
| vdrive | output | 1 | Vertical drive, active high |
| line_start | output | 1 | High for the first tick of each line |
| field_start | output | 1 | High for the first tick of each field |
| field_odd | output | 1 | 1 during the second field |
| line_num | output | 11 | Frame line number, from 1 |

## Verification
The sweep runs whole frames in both raster modes, so the mid-line start of the second field is always reached. A design that opens field two at tick 0 shifts the whole vertical interval by half a line and misplaces every equalizing pulse. Each boundary between the equalizing and broad-pulse sections is compared tick by tick for every section length, which exposes an off-by-one section length as a missing or extra notch. The blanking tail after the vertical interval is checked in the field where it lands mid-line, where a design that relies on line blanking alone ends it early. Gaps in the tick enable confirm that the strobes neither repeat nor get lost.

// File: rtl/tvs_pkg.sv
// Shared widths, tick constants and the per-standard configuration type for
// the composite sync generator. Assumes a line of exactly 320 ticks.
package tvs_pkg;

    localparam int TICK_W = 9;
    localparam int CFG_W  = 11;

    localparam logic [TICK_W-1:0] T_LAST      = 9'd319;
    localparam logic [TICK_W-1:0] T_HALF      = 9'd160;
    localparam logic [TICK_W-1:0] T_HALF_LAST = 9'd159;
    localparam logic [TICK_W-1:0] T_EDGE      = 9'd8;
    localparam logic [TICK_W-1:0] T_EQ_END    = 9'd20;
    localparam logic [TICK_W-1:0] T_BROAD_END = 9'd144;
    localparam logic [TICK_W-1:0] T_HS_END    = 9'd32;
    localparam logic [TICK_W-1:0] T_VD_ON     = 9'd16;

    typedef enum logic [1:0] {
        FAM_625   = 2'd0,
        FAM_NTSC1 = 2'd1,
        FAM_NTSC2 = 2'd2,
        FAM_PALM  = 2'd3
    } tvs_family_e;

    // Half-line boundaries of the vertical interval plus the line blanking width.
    typedef struct packed {
        logic [CFG_W-1:0]  total;
        logic [CFG_W-1:0]  pre_end;
        logic [CFG_W-1:0]  ser_end;
        logic [CFG_W-1:0]  post_end;
        logic [CFG_W-1:0]  vb_end;
        logic [CFG_W-1:0]  vd_end;
        logic [TICK_W-1:0] hb_w;
    } tvs_cfg_t;

    // Sort a standard code into its timing family; the unused code joins 625.
    function automatic tvs_family_e family_of(input logic [2:0] code);
        case (code)
            3'b010:  return FAM_NTSC1;
            3'b110:  return FAM_NTSC2;
            3'b011:  return FAM_PALM;
            default: return FAM_625;
        endcase
    endfunction

endpackage

// File: rtl/tvsync_std_decode.sv
// Turns the standard code and the progressive-mode input into the raster
// configuration. Purely combinational; assumes the line-count parameters are
// odd and larger than the vertical blanking span in half-lines.
module tvsync_std_decode
    import tvs_pkg::*;
#(
    parameter int LINES_625 = 625,
    parameter int LINES_525 = 525
) (
    input  logic [2:0] std_sel,
    input  logic       noninterlace,
    output tvs_cfg_t   cfg
);

    localparam logic [CFG_W-1:0] L625 = CFG_W'(LINES_625);
    localparam logic [CFG_W-1:0] L525 = CFG_W'(LINES_525);

    tvs_family_e       fam;
    logic [CFG_W-1:0]  base;
    logic [CFG_W-1:0]  eq_len;
    logic [CFG_W-1:0]  br_len;
    logic [CFG_W-1:0]  vb_len;
    logic [CFG_W-1:0]  vd_len;
    logic [TICK_W-1:0] hb_len;

    // Pick per-family section lengths in half-lines and the blanking width.
    always_comb begin
        fam = family_of(std_sel);
        unique case (fam)
            FAM_NTSC1: begin
                base = L525; eq_len = CFG_W'(6); br_len = CFG_W'(6);
                vb_len = CFG_W'(42); vd_len = CFG_W'(12); hb_len = TICK_W'(56);
            end
            FAM_NTSC2: begin
                base = L525; eq_len = CFG_W'(6); br_len = CFG_W'(6);
                vb_len = CFG_W'(38); vd_len = CFG_W'(12); hb_len = TICK_W'(53);
            end
            FAM_PALM: begin
                base = L525; eq_len = CFG_W'(6); br_len = CFG_W'(7);
                vb_len = CFG_W'(50); vd_len = CFG_W'(12); hb_len = TICK_W'(60);
            end
            default: begin
                base = L625; eq_len = CFG_W'(5); br_len = CFG_W'(5);
                vb_len = CFG_W'(50); vd_len = CFG_W'(20); hb_len = TICK_W'(60);
            end
        endcase
    end

    // Derive cumulative boundaries; progressive mode drops one line.
    always_comb begin
        cfg.total    = base - {{(CFG_W-1){1'b0}}, noninterlace};
        cfg.pre_end  = eq_len;
        cfg.ser_end  = eq_len + br_len;
        cfg.post_end = eq_len + br_len + eq_len;
        cfg.vb_end   = vb_len;
        cfg.vd_end   = vd_len;
        cfg.hb_w     = hb_len;
    end

endmodule

// File: rtl/tvsync_raster_cnt.sv
// Raster position counters: tick within line, frame line number, half-line
// index within the field, and the field flag. A field holds as many
// half-lines as the frame has lines, so with an odd total the second field
// opens mid-line. Advances only when tick_en is high.
module tvsync_raster_cnt
    import tvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CFG_W-1:0]  total,
    output logic [TICK_W-1:0] h,
    output logic [CFG_W-1:0]  line,
    output logic [CFG_W-1:0]  half,
    output logic              fid
);

    logic line_end;
    logic half_end;

    assign line_end = (h == T_LAST);
    assign half_end = (h == T_HALF_LAST) || line_end;

    // Tick counter and frame line number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h    <= '0;
            line <= CFG_W'(1);
        end else if (tick_en) begin
            h <= line_end ? '0 : h + TICK_W'(1);
            if (line_end) begin
                line <= (line >= total) ? CFG_W'(1) : line + CFG_W'(1);
            end
        end
    end

    // Half-line index within the field and the field flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half <= '0;
            fid  <= 1'b0;
        end else if (tick_en && half_end) begin
            if (half >= total - CFG_W'(1)) begin
                half <= '0;
                fid  <= ~fid;
            end else begin
                half <= half + CFG_W'(1);
            end
        end
    end

endmodule

// File: rtl/tvsync_pulse_gen.sv
// Decodes the raster position into sync, blanking, drive and strobes and
// registers them on each tick. Assumes the vertical-interval boundaries are
// ordered and lie inside one field.
module tvsync_pulse_gen
    import tvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CFG_W-1:0]  pre_end,
    input  logic [CFG_W-1:0]  ser_end,
    input  logic [CFG_W-1:0]  post_end,
    input  logic [CFG_W-1:0]  vb_end,
    input  logic [CFG_W-1:0]  vd_end,
    input  logic [TICK_W-1:0] hb_w,
    input  logic [TICK_W-1:0] h,
    input  logic [CFG_W-1:0]  line,
    input  logic [CFG_W-1:0]  half,
    input  logic              fid,
    output logic              csync,
    output logic              cblank,
    output logic              vdrive,
    output logic              line_start,
    output logic              field_start,
    output logic              field_odd,
    output logic [CFG_W-1:0]  line_num
);

    logic              second;
    logic [TICK_W-1:0] q;
    logic              in_eq;
    logic              in_broad;
    logic              cs_d;
    logic              cb_d;
    logic              vd_d;

    // Position within the current half-line.
    always_comb begin
        second = (h >= T_HALF);
        q      = second ? h - T_HALF : h;
    end

    // Select the pulse shape of the current half-line.
    always_comb begin
        in_eq    = (half < pre_end) || ((half >= ser_end) && (half < post_end));
        in_broad = (half >= pre_end) && (half < ser_end);
        if (in_eq) begin
            cs_d = (q >= T_EDGE) && (q < T_EQ_END);
        end else if (in_broad) begin
            cs_d = (q >= T_EDGE) && (q < T_BROAD_END);
        end else begin
            cs_d = !second && (h >= T_EDGE) && (h < T_HS_END);
        end
    end

    // Line blanking, vertical blanking and its tail, and vertical drive.
    always_comb begin
        cb_d = (h < hb_w) || (half < vb_end) || ((half == vb_end) && (q < hb_w));
        if (half == '0) begin
            vd_d = (q >= T_VD_ON);
        end else begin
            vd_d = (half < vd_end) || ((half == vd_end) && (q < T_VD_ON));
        end
    end

    // Output register, loaded once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csync       <= 1'b0;
            cblank      <= 1'b0;
            vdrive      <= 1'b0;
            line_start  <= 1'b0;
            field_start <= 1'b0;
            field_odd   <= 1'b0;
            line_num    <= CFG_W'(1);
        end else if (tick_en) begin
            csync       <= cs_d;
            cblank      <= cb_d;
            vdrive      <= vd_d;
            line_start  <= (h == '0);
            field_start <= (half == '0) && (q == '0);
            field_odd   <= fid;
            line_num    <= line;
        end
    end

endmodule

// File: rtl/tvsync_gen.sv
// Top of the multi-standard composite sync generator. Connects the standard
// decoder, the raster counters and the registered pulse decoder. Assumes a
// tick enable with 320 ticks per line and odd line-count parameters.
module tvsync_gen
    import tvs_pkg::*;
#(
    parameter int LINES_625 = 625,
    parameter int LINES_525 = 525
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [2:0]       std_sel,
    input  logic             noninterlace,
    output logic             csync,
    output logic             cblank,
    output logic             vdrive,
    output logic             line_start,
    output logic             field_start,
    output logic             field_odd,
    output logic [CFG_W-1:0] line_num
);

    tvs_cfg_t          cfg;
    logic [TICK_W-1:0] h;
    logic [CFG_W-1:0]  line;
    logic [CFG_W-1:0]  half;
    logic              fid;

    tvsync_std_decode #(
        .LINES_625 (LINES_625),
        .LINES_525 (LINES_525)
    ) u_decode (
        .std_sel      (std_sel),
        .noninterlace (noninterlace),
        .cfg          (cfg)
    );

    tvsync_raster_cnt u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .total   (cfg.total),
        .h       (h),
        .line    (line),
        .half    (half),
        .fid     (fid)
    );

    tvsync_pulse_gen u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .pre_end     (cfg.pre_end),
        .ser_end     (cfg.ser_end),
        .post_end    (cfg.post_end),
        .vb_end      (cfg.vb_end),
        .vd_end      (cfg.vd_end),
        .hb_w        (cfg.hb_w),
        .h           (h),
        .line        (line),
        .half        (half),
        .fid         (fid),
        .csync       (csync),
        .cblank      (cblank),
        .vdrive      (vdrive),
        .line_start  (line_start),
        .field_start (field_start),
        .field_odd   (field_odd),
        .line_num    (line_num)
    );

endmodule

// File: rtl/tvsync_chk.sv
// Port-level checker for the composite sync generator, attached by bind.
// Assumes the reset is synchronous and held low from time zero.
module tvsync_chk #(
    parameter int LINES_MAX = 625
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        csync,
    input logic        cblank,
    input logic        vdrive,
    input logic        line_start,
    input logic        field_start,
    input logic        field_odd,
    input logic [10:0] line_num
);

    AST_LINE_START_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> (cblank && !csync)); // R7

    AST_FIELD_START_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> (cblank && !csync && !vdrive)); // R8

    AST_DRIVE_INSIDE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        vdrive |-> cblank); // R9

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_num >= 11'd1) && (32'(line_num) <= LINES_MAX)); // R3

    AST_FIELD_FLIP_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (field_odd != $past(field_odd)) |-> field_start); // R10

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_en)) |->
        $stable({csync, cblank, vdrive, line_start, field_start, field_odd, line_num})); // R12

endmodule

bind tvsync_gen tvsync_chk #(.LINES_MAX(LINES_625)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .csync       (csync),
    .cblank      (cblank),
    .vdrive      (vdrive),
    .line_start  (line_start),
    .field_start (field_start),
    .field_odd   (field_odd),
    .line_num    (line_num)
);

// File: tb/sim_tvsync_gen.sv
module sim_tvsync_gen;

    localparam int CLK_PERIOD = 10;
    localparam int L625       = 55;
    localparam int L525       = 45;
    localparam int WD_CYCLES  = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  std_sel = 3'b101;
    logic        noninterlace = 1'b0;
    logic        csync, cblank, vdrive, line_start, field_start, field_odd;
    logic [10:0] line_num;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tvsync_gen #(.LINES_625(L625), .LINES_525(L525)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .std_sel(std_sel),
        .noninterlace(noninterlace), .csync(csync), .cblank(cblank),
        .vdrive(vdrive), .line_start(line_start), .field_start(field_start),
        .field_odd(field_odd), .line_num(line_num)
    );

    task automatic chk_val(input int act, input int exp, input string tag, input longint k);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s tick %0d: actual %0d expected %0d", tag, k, act, exp);
        end
    endtask

    // Expected outputs for raster position k, worked out from the requirements.
    task automatic check_pos(input logic [2:0] code, input logic ni, input longint k,
                             input bit hold);
        bit    is525 = (code == 3'd2) || (code == 3'd6) || (code == 3'd3);
        int    lines = (is525 ? L525 : L625) - int'(ni);
        int    pre   = is525 ? 6 : 5;
        int    brd   = (code == 3'd3) ? 7 : pre;
        int    hbw   = (code == 3'd2) ? 56 : (code == 3'd6) ? 53 : 60;
        int    vbh   = (code == 3'd2) ? 42 : (code == 3'd6) ? 38 : 50;
        int    vdh   = is525 ? 12 : 20;
        int    h     = int'(k % 320);
        int    q     = int'(k % 160);
        int    a     = int'((k / 160) % (2 * lines));
        bit    fodd  = (a >= lines);
        int    r     = fodd ? a - lines : a;
        int    ln    = int'((k / 320) % lines) + 1;
        bit    e_cs, e_cb, e_vd;
        string t_cs, t_cb, t_vd, t_fs, t_fo, t_ls;
        if (r < pre || (r >= pre + brd && r < 2 * pre + brd)) begin
            e_cs = (q >= 8) && (q < 20);  t_cs = "R5";
        end else if (r >= pre && r < pre + brd) begin
            e_cs = (q >= 8) && (q < 144); t_cs = "R6";
        end else begin
            e_cs = (h >= 8) && (h < 32);  t_cs = "R4";
        end
        e_cb = (h < hbw) || (r < vbh) || (r == vbh && q < hbw);
        t_cb = (r <= vbh) ? "R8" : "R7";
        if (r == 0) e_vd = (q >= 16);
        else        e_vd = (r < vdh) || (r == vdh && q < 16);
        // R2: codes outside the named-difference set are tagged by their mapping
        t_vd = (code == 3'd0 || code == 3'd1 || code == 3'd4 || code == 3'd7) ? "R2" : "R9";
        t_fs = (k == 0) ? "R1" : (ni ? "R11" : "R10");
        t_fo = ni ? "R11" : "R10";
        t_ls = "R3";
        if (hold) begin
            t_cs = "R12"; t_cb = "R12"; t_vd = "R12"; t_fs = "R12"; t_fo = "R12"; t_ls = "R12";
        end
        chk_val(int'(csync), int'(e_cs), t_cs, k);
        chk_val(int'(cblank), int'(e_cb), t_cb, k);
        chk_val(int'(vdrive), int'(e_vd), t_vd, k);
        chk_val(int'(line_start), int'(h == 0), t_ls, k);
        chk_val(int'(field_start), int'(r == 0 && q == 0), t_fs, k);
        chk_val(int'(field_odd), int'(fodd), t_fo, k);
        chk_val(int'(line_num), ln, t_ls, k);
    endtask

    task automatic run_cfg(input logic [2:0] code, input logic ni, input int ticks, input bit gaps);
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; std_sel = code; noninterlace = ni;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_val(int'({csync, cblank, vdrive, line_start, field_start}), 0, "R1", -1);
        chk_val(int'(line_num), 1, "R1", -1);
        chk_val(int'(field_odd), 0, "R1", -1);
        rst_n = 1'b1; tick_en = 1'b1;
        for (int k = 0; k < ticks; k++) begin
            @(negedge clk);
            check_pos(code, ni, longint'(k), 1'b0);
            if (gaps && (k % 731 == 5)) begin
                tick_en = 1'b0;
                repeat (3) begin
                    @(negedge clk);
                    check_pos(code, ni, longint'(k), 1'b1);
                end
                tick_en = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        run_cfg(3'd5, 1'b0, L625 * 320 + 400, 1'b0);
        run_cfg(3'd5, 1'b1, (L625 - 1) * 320 + 400, 1'b0);
        run_cfg(3'd2, 1'b0, L525 * 320 + 400, 1'b1);
        run_cfg(3'd6, 1'b0, L525 * 320 + 400, 1'b0);
        run_cfg(3'd3, 1'b0, L525 * 320 + 400, 1'b0);
        run_cfg(3'd2, 1'b1, (L525 - 1) * 320 + 400, 1'b0);
        run_cfg(3'd0, 1'b0, 9000, 1'b0);
        run_cfg(3'd1, 1'b0, 9000, 1'b0);
        run_cfg(3'd4, 1'b0, 9000, 1'b0);
        run_cfg(3'd7, 1'b0, 9000, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule